// File: doc/BRIEF.md
# Comparator Control and Edge Event Register Block

This block is the byte-wide register file that sits beside an analog comparator. It holds the comparator's tuning, mode, filter-period, reference-level and input-selection settings, and it watches the conditioned comparator output for edges. A rising change and a falling change are each caught in a sticky flag. Software clears a flag by writing a one to its bit. From those flags the block raises an interrupt line and a DMA request line, each under its own enables.

The block also decides whether the comparator may run. The comparator is active only when its enable bit is set and the two input selects differ, because selecting the same input on both sides would make the comparator oscillate. It also stops software from selecting sampling and windowing at the same time. Accesses use a plain synchronous byte bus. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`.

Register offsets: 0 tuning, 1 mode, 2 filter period, 3 status/control, 4 reference level, 5 input select. Offsets 6 and 7 read as zero.

Top module: `cmpctl_regs`

## Requirements
- R1: After reset, every register reads 0x00, and `irq_o`, `dma_req_o` and `cmp_active_o` are all 0.
- R2: Readback is masked per register:
  - Tuning (offset 0) keeps only bits 6:4 and 1:0 (mask 0x73).
  - Filter period (offset 2) and reference level (offset 4) keep all eight bits.
  - Input select (offset 5) keeps bits 5:0 and always reads bits 7:6 as zero.
  - Offsets 6 and 7 read 0x00.
- R3: In the mode register (offset 1), bit 7 selects sampling and bit 6 selects windowing. A write with both bits set stores bit 7 = 1 and bit 6 = 0. A write with only bit 6 set stores it.
- R4: `cmp_active_o` is 1 exactly when mode bit 0 (enable) is 1 and the plus select differs from the minus select. The plus select is input-select bits 5:3 and the minus select is bits 2:0.
- R5: While the comparator is active, a 0-to-1 change of `cmp_out_i` sets status bit 2 (rise flag). A 1-to-0 change sets status bit 1 (fall flag). Either flag is readable at the first clock edge after the change.
- R6: While the comparator is inactive, changes of `cmp_out_i` set no flag.
- R7: Writing 1 to status bit 2 or bit 1 clears that flag. Writing 0 leaves it unchanged. A write can never set a flag.
- R8: When an edge and a write-one-to-clear of the same flag occur in the same cycle, the flag ends up set.
- R9: `irq_o` is 1 when (rise flag and status bit 4) or (fall flag and status bit 3) is true.
- R10: `dma_req_o` is 1 when status bit 6 is set and either flag is set.
- R11: Status bit 0 reads `cmp_out_i` while the comparator is active. While it is inactive, it reads mode bit 3 (invert). Writes to status bit 0 have no effect. Status bits 5 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| cmp_out_i | input | 1 | Conditioned comparator output |
| irq_o | output | 1 | Edge interrupt |
| dma_req_o | output | 1 | Edge DMA request |
| cmp_active_o | output | 1 | Effective comparator enable |

## Verification
The hardest situation to reach is a clear write colliding with a fresh edge on the same flag. To produce it, the stimulus first parks the comparator output low for several cycles so that the previous-value register matches. It then raises the output and drives the clear write in the same half-cycle, so both reach the same clock edge. The forced-off condition from matching selects is reached only by rewriting the input-select register while the enable bit stays set. Edge suppression is checked the same way, by toggling the input while the block is inactive.

// File: rtl/cmpctl_pkg.sv
package cmpctl_pkg;
  localparam int REG_W = 8;
  localparam int SEL_W = 3;
  localparam int N_EDGE = 2;  // index 0 = falling, index 1 = rising

  localparam logic [2:0] OFS_TUNE   = 3'd0;
  localparam logic [2:0] OFS_MODE   = 3'd1;
  localparam logic [2:0] OFS_PERIOD = 3'd2;
  localparam logic [2:0] OFS_STAT   = 3'd3;
  localparam logic [2:0] OFS_REF    = 3'd4;
  localparam logic [2:0] OFS_MUX    = 3'd5;

  localparam logic [REG_W-1:0] TUNE_MASK = 8'h73;
  localparam logic [REG_W-1:0] MUX_MASK  = 8'h3F;

  localparam int MODE_EN  = 0;
  localparam int MODE_INV = 3;
  localparam int MODE_WIN = 6;
  localparam int MODE_SMP = 7;

  localparam int ST_OUT  = 0;
  localparam int ST_FALL = 1;
  localparam int ST_RISE = 2;
  localparam int ST_FIE  = 3;
  localparam int ST_RIE  = 4;
  localparam int ST_DMA  = 6;

  // sampling wins over windowing when both are requested
  function automatic logic [REG_W-1:0] mode_sanitize(input logic [REG_W-1:0] w);
    logic [REG_W-1:0] r;
    r = w;
    if (w[MODE_SMP]) r[MODE_WIN] = 1'b0;
    return r;
  endfunction

  function automatic logic edge_seen(input logic cur, input logic prev,
                                     input logic want_rise, input logic active);
    return active & (want_rise ? (cur & ~prev) : (~cur & prev));
  endfunction

  // a new event dominates a simultaneous clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic sel_clash(input logic [REG_W-1:0] mux);
    return mux[2*SEL_W-1:SEL_W] == mux[SEL_W-1:0];
  endfunction
endpackage

// File: rtl/cmpctl_cfg_regs.sv
module cmpctl_cfg_regs
  import cmpctl_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  tune_q,
  output logic [REG_W-1:0]  mode_q,
  output logic [REG_W-1:0]  period_q,
  output logic [REG_W-1:0]  ref_q,
  output logic [REG_W-1:0]  mux_q
);
  logic hit_tune, hit_mode, hit_period, hit_ref, hit_mux;

  assign hit_tune   = wr_en && (addr == ADDR_W'(OFS_TUNE));
  assign hit_mode   = wr_en && (addr == ADDR_W'(OFS_MODE));
  assign hit_period = wr_en && (addr == ADDR_W'(OFS_PERIOD));
  assign hit_ref    = wr_en && (addr == ADDR_W'(OFS_REF));
  assign hit_mux    = wr_en && (addr == ADDR_W'(OFS_MUX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tune_q   <= '0;
      mode_q   <= '0;
      period_q <= '0;
      ref_q    <= '0;
      mux_q    <= '0;
    end else begin
      if (hit_tune)   tune_q   <= wdata & TUNE_MASK;
      if (hit_mode)   mode_q   <= mode_sanitize(wdata);
      if (hit_period) period_q <= wdata;
      if (hit_ref)    ref_q    <= wdata;
      if (hit_mux)    mux_q    <= wdata & MUX_MASK;
    end
  end
endmodule

// File: rtl/cmpctl_edge_flags.sv
module cmpctl_edge_flags
  import cmpctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_in,
  input  logic              active,
  input  logic [N_EDGE-1:0] clr,
  output logic [N_EDGE-1:0] flag_q,
  output logic [N_EDGE-1:0] evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cmp_in;
  end

  for (genvar g = 0; g < N_EDGE; g++) begin : g_slot
    localparam logic IS_RISE = (g == 1);
    logic f_q;
    assign evt[g] = edge_seen(cmp_in, prev_q, IS_RISE, active);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= flag_next(f_q, evt[g], clr[g]);
    end
    assign flag_q[g] = f_q;
  end
endmodule

// File: rtl/cmpctl_req_gen.sv
module cmpctl_req_gen
  import cmpctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [REG_W-1:0]  ctl_wdata,
  input  logic [N_EDGE-1:0] flags,
  output logic              fall_ie_q,
  output logic              rise_ie_q,
  output logic              dma_en_q,
  output logic              irq,
  output logic              dma_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_ie_q <= 1'b0;
      rise_ie_q <= 1'b0;
      dma_en_q  <= 1'b0;
    end else if (ctl_we) begin
      fall_ie_q <= ctl_wdata[ST_FIE];
      rise_ie_q <= ctl_wdata[ST_RIE];
      dma_en_q  <= ctl_wdata[ST_DMA];
    end
  end

  assign irq     = (flags[1] & rise_ie_q) | (flags[0] & fall_ie_q);
  assign dma_req = dma_en_q & (|flags);
endmodule

// File: rtl/cmpctl_regs.sv
module cmpctl_regs
  import cmpctl_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              cmp_out_i,
  output logic              irq_o,
  output logic              dma_req_o,
  output logic              cmp_active_o
);
  logic [REG_W-1:0]  tune_q, mode_q, period_q, ref_q, mux_q;
  logic [REG_W-1:0]  stat_rd;
  logic [N_EDGE-1:0] edge_flag, edge_evt, edge_clr;
  logic              stat_we, fall_ie, rise_ie, dma_en;
  logic              active;

  cmpctl_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .tune_q(tune_q), .mode_q(mode_q), .period_q(period_q), .ref_q(ref_q), .mux_q(mux_q)
  );

  assign active       = mode_q[MODE_EN] & ~sel_clash(mux_q);
  assign cmp_active_o = active;

  assign stat_we  = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign edge_clr = stat_we ? {bus_wdata[ST_RISE], bus_wdata[ST_FALL]} : '0;

  cmpctl_edge_flags u_edges (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_out_i), .active(active),
    .clr(edge_clr), .flag_q(edge_flag), .evt(edge_evt)
  );

  cmpctl_req_gen u_req (
    .clk(clk), .rst_n(rst_n), .ctl_we(stat_we), .ctl_wdata(bus_wdata), .flags(edge_flag),
    .fall_ie_q(fall_ie), .rise_ie_q(rise_ie), .dma_en_q(dma_en),
    .irq(irq_o), .dma_req(dma_req_o)
  );

  always_comb begin
    stat_rd          = '0;
    stat_rd[ST_OUT]  = active ? cmp_out_i : mode_q[MODE_INV];
    stat_rd[ST_FALL] = edge_flag[0];
    stat_rd[ST_RISE] = edge_flag[1];
    stat_rd[ST_FIE]  = fall_ie;
    stat_rd[ST_RIE]  = rise_ie;
    stat_rd[ST_DMA]  = dma_en;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_TUNE))        bus_rdata = tune_q;
    else if (bus_addr == ADDR_W'(OFS_MODE))   bus_rdata = mode_q;
    else if (bus_addr == ADDR_W'(OFS_PERIOD)) bus_rdata = period_q;
    else if (bus_addr == ADDR_W'(OFS_STAT))   bus_rdata = stat_rd;
    else if (bus_addr == ADDR_W'(OFS_REF))    bus_rdata = ref_q;
    else if (bus_addr == ADDR_W'(OFS_MUX))    bus_rdata = mux_q;
  end
endmodule

// File: rtl/cmpctl_regs_chk.sv
module cmpctl_regs_chk
  import cmpctl_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic              irq_o,
  input logic              dma_req_o,
  input logic              cmp_active_o,
  input logic [REG_W-1:0]  mode_q,
  input logic [REG_W-1:0]  mux_q,
  input logic [N_EDGE-1:0] edge_flag,
  input logic [N_EDGE-1:0] edge_evt
);
  logic clr_rise_wr;
  assign clr_rise_wr = bus_wr && (bus_addr == ADDR_W'(OFS_STAT)) && bus_wdata[ST_RISE];

  assert_sample_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_MODE) && bus_wdata[MODE_SMP]) |=> !mode_q[MODE_WIN]);

  assert_active_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_active_o |-> (mux_q[5:3] != mux_q[2:0]) && mode_q[MODE_EN]);

  assert_rise_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt[1] |=> edge_flag[1]);

  assert_fall_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt[0] |=> edge_flag[0]);

  assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_active_o |-> edge_evt == '0);

  assert_set_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag[1] && !$past(edge_flag[1])) |-> $past(edge_evt[1]));

  assert_event_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt[1] && clr_rise_wr) |=> edge_flag[1]);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (edge_flag != '0));

  assert_dma_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_o |-> (edge_flag != '0));
endmodule

bind cmpctl_regs cmpctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .irq_o(irq_o), .dma_req_o(dma_req_o), .cmp_active_o(cmp_active_o),
  .mode_q(mode_q), .mux_q(mux_q), .edge_flag(edge_flag), .edge_evt(edge_evt)
);

// File: tb/cmpctl_regs_tb_top.sv
`timescale 1ns/1ps
module cmpctl_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cmp_out_i = 1'b0;
  logic       irq_o, dma_req_o, cmp_active_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  cmpctl_regs #(.ADDR_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cmp_out_i(cmp_out_i), .irq_o(irq_o), .dma_req_o(dma_req_o),
    .cmp_active_o(cmp_active_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle(input logic v);
    @(negedge clk);
    cmp_out_i = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1 reg after reset", d, 8'h00);
    end
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    check("R1 dma", {7'd0, dma_req_o}, 8'h00);
    check("R1 active", {7'd0, cmp_active_o}, 8'h00);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    wr(3'd0, 8'hFF); rd(3'd0, d); check("R2 tune mask", d, 8'h73);
    wr(3'd2, 8'hA5); rd(3'd2, d); check("R2 period", d, 8'hA5);
    wr(3'd4, 8'h3C); rd(3'd4, d); check("R2 ref", d, 8'h3C);
    wr(3'd5, 8'hFF); rd(3'd5, d); check("R2 mux mask", d, 8'h3F);
    rd(3'd6, d); check("R2 offset 6", d, 8'h00);
    rd(3'd7, d); check("R2 offset 7", d, 8'h00);
    wr(3'd5, 8'h0A);
  endtask

  task automatic t_exclusive;
    logic [7:0] d;
    wr(3'd1, 8'hC0); rd(3'd1, d); check("R3 both set", d, 8'h80);
    wr(3'd1, 8'h40); rd(3'd1, d); check("R3 window only", d, 8'h40);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_active;
    wr(3'd5, 8'h0A); wr(3'd1, 8'h01);
    check("R4 enabled distinct sel", {7'd0, cmp_active_o}, 8'h01);
    wr(3'd5, 8'h12);
    check("R4 matching sel forces off", {7'd0, cmp_active_o}, 8'h00);
    wr(3'd5, 8'h0A);
    check("R4 back on", {7'd0, cmp_active_o}, 8'h01);
    wr(3'd1, 8'h00);
    check("R4 disabled", {7'd0, cmp_active_o}, 8'h00);
  endtask

  task automatic t_status_out;
    logic [7:0] d;
    settle(1'b1);
    wr(3'd1, 8'h08); rd(3'd3, d); check("R11 inactive reads invert", d & 8'h01, 8'h01);
    wr(3'd1, 8'h00); wr(3'd3, 8'hA1); rd(3'd3, d);
    check("R11 write to out bit and reserved ignored", d, 8'h00);
    wr(3'd1, 8'h01); rd(3'd3, d); check("R11 active reads input", d & 8'h01, 8'h01);
    settle(1'b0); rd(3'd3, d); check("R11 active reads input low", d & 8'h01, 8'h00);
    wr(3'd3, 8'h06);
  endtask

  task automatic t_edges;
    logic [7:0] d;
    wr(3'd1, 8'h01); settle(1'b0); wr(3'd3, 8'h06);
    @(negedge clk); cmp_out_i = 1'b1;
    @(negedge clk); rd(3'd3, d); check("R5 rise flag one edge later", d & 8'h06, 8'h04);
    @(negedge clk); cmp_out_i = 1'b0;
    @(negedge clk); rd(3'd3, d); check("R5 fall flag", d & 8'h06, 8'h06);
    wr(3'd3, 8'h00); rd(3'd3, d); check("R7 zero write keeps flags", d & 8'h06, 8'h06);
    wr(3'd3, 8'h04); rd(3'd3, d); check("R7 clear rise only", d & 8'h06, 8'h02);
    wr(3'd3, 8'h02); rd(3'd3, d); check("R7 clear fall", d & 8'h06, 8'h00);
  endtask

  task automatic t_inactive;
    logic [7:0] d;
    wr(3'd1, 8'h00); settle(1'b0);
    settle(1'b1); settle(1'b0);
    rd(3'd3, d); check("R6 disabled no flags", d & 8'h06, 8'h00);
    wr(3'd1, 8'h01); wr(3'd5, 8'h1B);  // plus 3, minus 3
    settle(1'b1); settle(1'b0);
    rd(3'd3, d); check("R6 clash no flags", d & 8'h06, 8'h00);
    wr(3'd5, 8'h0A);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d;
    wr(3'd1, 8'h01); settle(1'b0); wr(3'd3, 8'h06);
    @(negedge clk);
    cmp_out_i = 1'b1; bus_addr = 3'd3; bus_wdata = 8'h04; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(3'd3, d); check("R8 event wins over clear", d & 8'h04, 8'h04);
    wr(3'd3, 8'h06);
  endtask

  task automatic t_requests;
    wr(3'd1, 8'h01); settle(1'b0); wr(3'd3, 8'h06);
    wr(3'd3, 8'h10);
    settle(1'b1);
    check("R9 rise irq", {7'd0, irq_o}, 8'h01);
    check("R10 dma off", {7'd0, dma_req_o}, 8'h00);
    wr(3'd3, 8'h14);
    check("R9 irq drops on clear", {7'd0, irq_o}, 8'h00);
    wr(3'd3, 8'h08);
    settle(1'b0);
    check("R9 fall irq", {7'd0, irq_o}, 8'h01);
    wr(3'd3, 8'h40);
    check("R9 no enables no irq", {7'd0, irq_o}, 8'h00);
    check("R10 dma with fall flag", {7'd0, dma_req_o}, 8'h01);
    wr(3'd3, 8'h46);
    check("R10 dma drops on clear", {7'd0, dma_req_o}, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_readback();
    t_exclusive();
    t_active();
    t_status_out();
    t_edges();
    t_inactive();
    t_same_cycle();
    t_requests();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule